// File: doc/BRIEF.md
# External Bus Area Cycle Timer

This block runs single external memory accesses for one address area of a processor bus controller. A request carries an address, a read/write flag, write data and an optional burst beat count. When the three area bits of the address match the area code, the block starts an access. It drives chip select, read strobe, write strobe, a one-cycle address-valid marker and a data-output enable. When the access ends it returns read data and a one-cycle completion pulse. A request whose area bits do not match is dropped.

Configuration inputs set the timing of each phase of the access:
- a setup phase, in which chip select is active before the strobe;
- a strobe phase, which covers the programmed wait states and any burst beats;
- a hold phase, in which chip select is still active after the strobe.

An asynchronous wait input can extend the last strobe cycle for as long as it is held. A PC-card mode adds setup and hold extensions, adds extra wait states on top of the base waits, and limits the bus to 8 or 16 bits.

Top module: `xbus_area_timer`

## Requirements
- R1: An access starts only when `req_valid` is high, the block is idle, and `req_addr[28:26]` equals 3'b110. Any other request is dropped: chip select stays inactive and no `done` pulse is produced.
- R2: The strobe phase lasts 1+W cycles. W is set by `cfg_wait`: codes 0, 1, 2, 3, 4, 5, 6, 7 give 0, 1, 2, 3, 6, 9, 12, 15 wait cycles.
- R3: Chip select is active with both strobes high for S cycles before the strobe, where S equals `cfg_setup` (0 or 1). `bus_addr_vld` is high for exactly one cycle, the first cycle in which chip select is active. `bus_addr` carries the request address during the access.
- R4: After the strobe ends, chip select stays active for H cycles, where H equals `cfg_hold` (0 to 3). In the next cycle `done` is high for exactly one clock, with chip select inactive.
- R5: `ext_wait` (active high) passes through two flops. Its synchronized value is used only in the last cycle of a beat. While it is high there, the strobe is extended one cycle at a time, with no upper limit. A high level earlier in the wait count has no effect.
- R6: When `cfg_burst`=1, `req_beats` extra beats follow the first beat, each lasting 2+`cfg_wait` cycles, with the strobe held low throughout. For reads, `rd_valid` pulses once per beat. When `cfg_burst`=0, `req_beats` is ignored.
- R7: When `cfg_pcard`=1, `cfg_pc_setup` and `cfg_pc_hold` add extension cycles to S and H. Codes 0, 1, 2, 3 add 0, 2, 5, 14 cycles, and each total is limited to 15.
- R8: When `cfg_pcard`=1, `cfg_pc_wait` adds waits to W. Codes 0, 1, 2, 3 add 0, 10, 25, 50 cycles.
- R9: Read data is masked to the bus width set by `cfg_width`: 0 keeps bits 7:0, 1 keeps bits 15:0, 2 and 3 keep 32 bits. In PC-card mode, codes 2 and 3 keep only 16 bits.
- R10: Reads pull `bus_rd_n` low and never `bus_we_n`. Writes pull `bus_we_n` low, drive `bus_wdata`, and hold `bus_data_oe` high for every cycle in which chip select is active. A strobe is never low while chip select is inactive.
- R11: After reset, `bus_cs_n`, `bus_rd_n` and `bus_we_n` are high, and `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Request address; bits 28:26 select the area |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_beats | input | BEAT_W | Extra burst beats |
| cfg_wait | input | 3 | Base wait code |
| cfg_setup | input | 1 | Setup cycles (0/1) |
| cfg_hold | input | 2 | Hold cycles (0-3) |
| cfg_burst | input | 1 | Burst enable |
| cfg_pcard | input | 1 | PC-card mode |
| cfg_pc_setup | input | 2 | PC-card setup extension code |
| cfg_pc_hold | input | 2 | PC-card hold extension code |
| cfg_pc_wait | input | 2 | PC-card extra wait code |
| cfg_width | input | 2 | Bus width code |
| ext_wait | input | 1 | Asynchronous wait request |
| bus_rdata | input | DATA_W | Data returned by the bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr_vld | output | 1 | First-cycle address marker |
| bus_data_oe | output | 1 | Write data output enable |
| bus_addr | output | ADDR_W | Latched address |
| bus_wdata | output | DATA_W | Latched write data |
| done | output | 1 | Access complete pulse |
| rd_valid | output | 1 | Read beat data valid |
| rdata | output | DATA_W | Masked read data |

## Verification
The bench builds the block with its defaults: a 29-bit address, 32-bit data and a 2-bit beat count. These widths make all three bus widths reachable, including the PC-card narrowing from 32 to 16 bits. They also allow up to three extra burst beats and the largest combined wait of 15+50 cycles. With these values the bench reaches both ends of the setup and hold limits and the deepest PC-card wait count. It also covers both timings of the wait input: released while the programmed wait count is still running, and held past the last programmed cycle.

// File: rtl/xbt_pkg.sv
package xbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  // Largest combined wait: 15 base plus 50 PC-card
  localparam int unsigned XB_MAX_WAIT = 65;
  localparam int unsigned XB_LEAD_MAX = 15;

  function automatic logic [6:0] base_wait_f(input logic [2:0] code);
    logic [6:0] r;
    case (code)
      3'd4:    r = 7'd6;
      3'd5:    r = 7'd9;
      3'd6:    r = 7'd12;
      3'd7:    r = 7'd15;
      default: r = {4'd0, code};
    endcase
    return r;
  endfunction

  function automatic logic [6:0] pc_wait_f(input logic [1:0] code);
    logic [6:0] r;
    case (code)
      2'd1:    r = 7'd10;
      2'd2:    r = 7'd25;
      2'd3:    r = 7'd50;
      default: r = 7'd0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] pc_ext_f(input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'd1:    r = 4'd2;
      2'd2:    r = 4'd5;
      2'd3:    r = 4'd14;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] lead_clamp_f(input logic [4:0] v);
    return (v > 5'(XB_LEAD_MAX)) ? 4'(XB_LEAD_MAX) : v[3:0];
  endfunction

endpackage

// File: rtl/xbt_wait_sync.sv
module xbt_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/xbt_timing_calc.sv
module xbt_timing_calc
  import xbt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned LANE_W = 3
) (
  input  logic [2:0]        wait_code,
  input  logic              setup_code,
  input  logic [1:0]        hold_code,
  input  logic              pcard,
  input  logic [1:0]        pc_setup_code,
  input  logic [1:0]        pc_hold_code,
  input  logic [1:0]        pc_wait_code,
  input  logic [1:0]        width_code,
  output logic [3:0]        setup_n,
  output logic [CNT_W-1:0]  wait_n,
  output logic [3:0]        hold_n,
  output logic [3:0]        beat_n,
  output logic [DATA_W-1:0] lane_mask
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [4:0]        su_sum;
  logic [4:0]        ho_sum;
  logic [7:0]        wt_sum;
  logic [LANE_W-1:0] lanes;

  always_comb begin
    su_sum  = {4'd0, setup_code} + (pcard ? {1'b0, pc_ext_f(pc_setup_code)} : 5'd0);
    ho_sum  = {3'd0, hold_code}  + (pcard ? {1'b0, pc_ext_f(pc_hold_code)}  : 5'd0);
    wt_sum  = {1'b0, base_wait_f(wait_code)} + (pcard ? {1'b0, pc_wait_f(pc_wait_code)} : 8'd0);
    setup_n = lead_clamp_f(su_sum);
    hold_n  = lead_clamp_f(ho_sum);
    wait_n  = CNT_W'(wt_sum);
    beat_n  = 4'd2 + {1'b0, wait_code};
    case (width_code)
      2'd0:    lanes = LANE_W'(1);
      2'd1:    lanes = LANE_W'(2);
      default: lanes = pcard ? LANE_W'(2) : LANE_W'(LANES);
    endcase
  end

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign lane_mask[b*8 +: 8] = {8{lanes > LANE_W'(b)}};
    end
  endgenerate
endmodule

// File: rtl/xbt_seq.sv
module xbt_seq
  import xbt_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        setup_n,
  input  logic [CNT_W-1:0]  wait_n,
  input  logic [3:0]        hold_n,
  input  logic [3:0]        beat_n,
  input  logic [BEAT_W-1:0] beats,
  input  logic              wait_sync,
  output seq_state_e        state,
  output logic              first_cycle,
  output logic              strobe_last,
  output logic              beat_end
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  wait_q;
  logic [3:0]        hold_q;
  logic [3:0]        beat_q;
  logic [BEAT_W-1:0] left_q;
  logic              first_q;

  assign strobe_last = (state == ST_STROBE) && (cnt_q == '0);
  assign beat_end    = strobe_last && !wait_sync;
  assign first_cycle = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      beat_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wait_q  <= wait_n;
            hold_q  <= hold_n;
            beat_q  <= beat_n;
            left_q  <= beats;
            first_q <= 1'b1;
            if (setup_n != 4'd0) begin
              state <= ST_SETUP;
              cnt_q <= CNT_W'(setup_n) - CNT_ONE;
            end else begin
              state <= ST_STROBE;
              cnt_q <= wait_n;
            end
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state <= ST_STROBE;
            cnt_q <= wait_q;
          end else begin
            cnt_q <= cnt_q - CNT_ONE;
          end
        end
        ST_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
          end else if (!wait_sync) begin
            if (left_q != '0) begin
              left_q <= left_q - BEAT_W'(1);
              cnt_q  <= CNT_W'(beat_q) - CNT_ONE;
            end else if (hold_q != 4'd0) begin
              state <= ST_HOLD;
              cnt_q <= CNT_W'(hold_q) - CNT_ONE;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state <= ST_DONE;
          else             cnt_q <= cnt_q - CNT_ONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_area_timer.sv
module xbus_area_timer
  import xbt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 29,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BEAT_W    = 2,
  parameter int unsigned AREA_MSB  = 28,
  parameter logic [2:0]  AREA_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic [2:0]        cfg_wait,
  input  logic              cfg_setup,
  input  logic [1:0]        cfg_hold,
  input  logic              cfg_burst,
  input  logic              cfg_pcard,
  input  logic [1:0]        cfg_pc_setup,
  input  logic [1:0]        cfg_pc_hold,
  input  logic [1:0]        cfg_pc_wait,
  input  logic [1:0]        cfg_width,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n,
  output logic              bus_addr_vld,
  output logic              bus_data_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned CNT_W  = $clog2(XB_MAX_WAIT + 1);
  localparam int unsigned LANE_W = $clog2(DATA_W / 8) + 1;

  // Named internal events, also used by the bound checker
  logic              area_hit;
  logic              seq_idle;
  logic              start;
  logic              wait_sync;
  logic              strobe_last;
  logic              beat_end;
  logic              first_cycle;
  seq_state_e        state;

  logic [3:0]        setup_n;
  logic [CNT_W-1:0]  wait_n;
  logic [3:0]        hold_n;
  logic [3:0]        beat_n;
  logic [DATA_W-1:0] lane_mask;
  logic [BEAT_W-1:0] beats_eff;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic              write_q;
  logic              rd_valid_q;

  assign area_hit  = (req_addr[AREA_MSB -: 3] == AREA_CODE);
  assign seq_idle  = (state == ST_IDLE);
  assign start     = req_valid && area_hit && seq_idle;
  assign beats_eff = cfg_burst ? req_beats : '0;

  xbt_wait_sync #(.STAGES(2)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_wait),
    .sync_out (wait_sync)
  );

  xbt_timing_calc #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LANE_W(LANE_W)) calc_i (
    .wait_code     (cfg_wait),
    .setup_code    (cfg_setup),
    .hold_code     (cfg_hold),
    .pcard         (cfg_pcard),
    .pc_setup_code (cfg_pc_setup),
    .pc_hold_code  (cfg_pc_hold),
    .pc_wait_code  (cfg_pc_wait),
    .width_code    (cfg_width),
    .setup_n       (setup_n),
    .wait_n        (wait_n),
    .hold_n        (hold_n),
    .beat_n        (beat_n),
    .lane_mask     (lane_mask)
  );

  xbt_seq #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .setup_n     (setup_n),
    .wait_n      (wait_n),
    .hold_n      (hold_n),
    .beat_n      (beat_n),
    .beats       (beats_eff),
    .wait_sync   (wait_sync),
    .state       (state),
    .first_cycle (first_cycle),
    .strobe_last (strobe_last),
    .beat_end    (beat_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      rdata_q    <= '0;
      write_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= beat_end && !write_q;
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= lane_mask;
        write_q <= req_write;
      end
      if (beat_end && !write_q) rdata_q <= bus_rdata & mask_q;
    end
  end

  logic active;
  assign active       = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign bus_cs_n     = !active;
  assign bus_rd_n     = !((state == ST_STROBE) && !write_q);
  assign bus_we_n     = !((state == ST_STROBE) && write_q);
  assign bus_addr_vld = first_cycle;
  assign bus_data_oe  = active && write_q;
  assign bus_addr     = addr_q;
  assign bus_wdata    = wdata_q;
  assign done         = (state == ST_DONE);
  assign rd_valid     = rd_valid_q;
  assign rdata        = rdata_q;
endmodule

// File: rtl/xbt_checker.sv
module xbt_checker #(
  parameter logic [2:0] AREA_CODE = 3'b110
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_area,
  input logic       seq_idle,
  input logic       strobe_last,
  input logic       wait_sync,
  input logic       bus_cs_n,
  input logic       bus_rd_n,
  input logic       bus_we_n,
  input logic       bus_addr_vld,
  input logic       done
);
  // R1
  r1_area_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && req_valid && (req_area != AREA_CODE)) |=> seq_idle);

  // R10
  r10_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we_n));

  // R10
  r10_strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);

  // R4
  r4_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  r4_done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_cs_n && $past(!bus_cs_n)));

  // R3
  r3_addr_vld_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_vld |-> (!bus_cs_n && $past(bus_cs_n)));

  // R5
  r5_wait_extends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_last && wait_sync) |=> (!bus_rd_n || !bus_we_n));
endmodule

bind xbus_area_timer xbt_checker #(.AREA_CODE(AREA_CODE)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_area     (req_addr[AREA_MSB -: 3]),
  .seq_idle     (seq_idle),
  .strobe_last  (strobe_last),
  .wait_sync    (wait_sync),
  .bus_cs_n     (bus_cs_n),
  .bus_rd_n     (bus_rd_n),
  .bus_we_n     (bus_we_n),
  .bus_addr_vld (bus_addr_vld),
  .done         (done)
);

// File: tb/xbus_area_timer_tb_top.sv
`timescale 1ns/1ps
module xbus_area_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [28:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_beats = '0;
  logic [2:0]  cfg_wait = '0;
  logic        cfg_setup = 1'b0;
  logic [1:0]  cfg_hold = '0;
  logic        cfg_burst = 1'b0;
  logic        cfg_pcard = 1'b0;
  logic [1:0]  cfg_pc_setup = '0;
  logic [1:0]  cfg_pc_hold = '0;
  logic [1:0]  cfg_pc_wait = '0;
  logic [1:0]  cfg_width = '0;
  logic        ext_wait = 1'b0;
  logic [31:0] bus_rdata = 32'hA5C3_96F1;
  logic        bus_cs_n, bus_rd_n, bus_we_n, bus_addr_vld, bus_data_oe;
  logic [28:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        done, rd_valid;
  logic [31:0] rdata;

  always #2 clk = ~clk;

  xbus_area_timer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_beats(req_beats),
    .cfg_wait(cfg_wait), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_burst(cfg_burst), .cfg_pcard(cfg_pcard), .cfg_pc_setup(cfg_pc_setup),
    .cfg_pc_hold(cfg_pc_hold), .cfg_pc_wait(cfg_pc_wait), .cfg_width(cfg_width),
    .ext_wait(ext_wait), .bus_rdata(bus_rdata), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_addr_vld(bus_addr_vld),
    .bus_data_oe(bus_data_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(done), .rd_valid(rd_valid), .rdata(rdata)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Vector layout: [18]write [17:15]wait [14]setup [13:12]hold [11]burst
  // [10:9]beats [8]pcard [7:6]pc_setup [5:4]pc_hold [3:2]pc_wait [1:0]width
  localparam int NVEC = 10;
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2},
    {1'b0, 3'd3, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b1, 3'd4, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1},
    {1'b0, 3'd7, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2},
    {1'b0, 3'd2, 1'b1, 2'd1, 1'b1, 2'd3, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1},
    {1'b0, 3'd5, 1'b0, 2'd0, 1'b0, 2'd3, 1'b0, 2'd0, 2'd0, 2'd0, 2'd3},
    {1'b0, 3'd1, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 2'd3, 2'd3, 2'd1, 2'd2},
    {1'b1, 3'd6, 1'b0, 2'd2, 1'b0, 2'd0, 1'b1, 2'd1, 2'd2, 2'd2, 2'd0},
    {1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd3, 2'd1},
    {1'b1, 3'd3, 1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2}
  };

  // Independent restatement of the timing rules
  function automatic int e_base(input int c);
    return (c <= 3) ? c : (3 * c - 6);
  endfunction
  function automatic int e_ext(input int c);
    int t [4] = '{0, 2, 5, 14};
    return t[c];
  endfunction
  function automatic int e_pcw(input int c);
    int t [4] = '{0, 10, 25, 50};
    return t[c];
  endfunction
  function automatic int e_min15(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  int cs_cnt, su_cnt, st_cnt, ho_cnt, av_cnt, rv_cnt, oe_cnt, rdlow_cnt;
  int got_done, done_cs_hi;
  logic [28:0] seen_addr;
  logic [31:0] seen_wdata;

  task automatic run_access(input logic [18:0] v, input logic [28:0] addr, input int drop_at);
    int seen_str;
    cfg_wait = v[17:15]; cfg_setup = v[14]; cfg_hold = v[13:12];
    cfg_burst = v[11]; req_beats = v[10:9]; cfg_pcard = v[8];
    cfg_pc_setup = v[7:6]; cfg_pc_hold = v[5:4]; cfg_pc_wait = v[3:2];
    cfg_width = v[1:0];
    req_addr = addr; req_write = v[18]; req_wdata = 32'h1357_9BDF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cs_cnt = 0; su_cnt = 0; st_cnt = 0; ho_cnt = 0; av_cnt = 0; rv_cnt = 0;
    oe_cnt = 0; rdlow_cnt = 0; got_done = 0; done_cs_hi = 0; seen_str = 0;
    seen_addr = '0; seen_wdata = '0;
    for (int i = 0; i < 400 && got_done == 0; i++) begin
      if (!bus_cs_n) begin
        cs_cnt++;
        seen_addr = bus_addr;
        seen_wdata = bus_wdata;
        if (bus_data_oe) oe_cnt++;
        if (!bus_rd_n || !bus_we_n) begin st_cnt++; seen_str = 1; end
        else if (seen_str == 0) su_cnt++;
        else ho_cnt++;
      end
      if (!bus_rd_n) rdlow_cnt++;
      if (bus_addr_vld) av_cnt++;
      if (rd_valid) rv_cnt++;
      if (drop_at != 0 && st_cnt == drop_at) ext_wait = 1'b0;
      if (done) begin got_done = 1; done_cs_hi = int'(bus_cs_n); end
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  localparam logic [28:0] HIT_ADDR  = {3'b110, 26'h012_3456};
  localparam logic [28:0] MISS_ADDR = {3'b101, 26'h000_0040};

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 cs_n", 32'(bus_cs_n), 1);
    chk("R11 rd_n", 32'(bus_rd_n), 1);
    chk("R11 we_n", 32'(bus_we_n), 1);
    chk("R11 done", 32'(done), 0);
    chk("R11 rd_valid", 32'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      logic [18:0] v;
      int wr, wc, su, ho, pc, exp_su, exp_ho, exp_st, nb;
      logic [31:0] exp_rd;
      v = VEC[k];
      wr = int'(v[18]); wc = int'(v[17:15]); su = int'(v[14]); ho = int'(v[13:12]);
      pc = int'(v[8]);
      nb = v[11] ? int'(v[10:9]) : 0;                        // R6
      exp_su = pc ? e_min15(su + e_ext(int'(v[7:6]))) : su;  // R3 R7
      exp_ho = pc ? e_min15(ho + e_ext(int'(v[5:4]))) : ho;  // R4 R7
      exp_st = 1 + e_base(wc) + (pc ? e_pcw(int'(v[3:2])) : 0) + nb * (2 + wc); // R2 R6 R8
      case (v[1:0])                                          // R9
        2'd0:    exp_rd = 32'h0000_00F1;
        2'd1:    exp_rd = 32'h0000_96F1;
        default: exp_rd = pc ? 32'h0000_96F1 : 32'hA5C3_96F1;
      endcase
      run_access(v, HIT_ADDR, 0);
      chk($sformatf("R3 R7 setup v%0d", k), 32'(su_cnt), 32'(exp_su));
      chk($sformatf("R2 R6 R8 strobe v%0d", k), 32'(st_cnt), 32'(exp_st));
      chk($sformatf("R4 R7 hold v%0d", k), 32'(ho_cnt), 32'(exp_ho));
      chk($sformatf("R3 addr_vld v%0d", k), 32'(av_cnt), 1);
      chk($sformatf("R3 bus_addr v%0d", k), 32'(seen_addr), 32'(HIT_ADDR));
      chk($sformatf("R4 done v%0d", k), 32'(got_done), 1);
      chk($sformatf("R4 cs at done v%0d", k), 32'(done_cs_hi), 1);
      if (wr != 0) begin
        chk($sformatf("R10 oe v%0d", k), 32'(oe_cnt), 32'(cs_cnt));
        chk($sformatf("R10 no rd v%0d", k), 32'(rdlow_cnt), 0);
        chk($sformatf("R10 wdata v%0d", k), seen_wdata, 32'h1357_9BDF);
        chk($sformatf("R6 no rd_valid v%0d", k), 32'(rv_cnt), 0);
      end else begin
        chk($sformatf("R10 no oe v%0d", k), 32'(oe_cnt), 0);
        chk($sformatf("R6 rd_valid v%0d", k), 32'(rv_cnt), 32'(nb + 1));
        chk($sformatf("R9 rdata v%0d", k), rdata, exp_rd);
      end
    end

    // R1: area miss dropped
    begin
      int cs_seen, dn_seen;
      cs_seen = 0; dn_seen = 0;
      cfg_wait = 3'd0; cfg_setup = 1'b0; cfg_hold = 2'd0; cfg_burst = 1'b0; cfg_pcard = 1'b0;
      req_addr = MISS_ADDR; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (!bus_cs_n) cs_seen++;
        if (done) dn_seen++;
        @(negedge clk);
      end
      chk("R1 miss cs", 32'(cs_seen), 0);
      chk("R1 miss done", 32'(dn_seen), 0);
    end

    // R5: wait held past last programmed cycle, released at strobe cycle 5
    ext_wait = 1'b1;
    repeat (3) @(negedge clk);
    run_access({1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2}, HIT_ADDR, 5);
    chk("R5 stretched strobe", 32'(st_cnt), 7);
    chk("R5 stretched done", 32'(got_done), 1);

    // R5: wait released while programmed waits still run: no effect
    ext_wait = 1'b1;
    repeat (3) @(negedge clk);
    run_access({1'b0, 3'd7, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2}, HIT_ADDR, 3);
    chk("R5 early wait ignored", 32'(st_cnt), 16);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule